// File: doc/BRIEF.md
# UART receive buffer control and error status

This block sits between a UART deserializer and the register interface of a small microcontroller. Each time the deserializer finishes a character it strobes the frame contents (eight data bits, the received parity bit and the received stop bit) into a one-entry holding stage. From there the character moves into a one-byte receive buffer as soon as that buffer is free. Software reads the byte through a data register, and that read frees the buffer.

While a character moves into the buffer, the block checks parity if parity checking is on. It checks the stop bit when a frame arrives. It flags an overrun when a third character arrives while the buffer and the holding stage are both occupied. The error flags are sticky and are cleared by writing ones. A single enable bit gates the whole receive path. Dropping that bit empties the receive path, clears every flag, and sends a one-cycle flush pulse to the companion transmit buffer. An interrupt request line reports buffer-full, and optionally errors as well, depending on a mode bit that can only be changed while the block is disabled.

Top module: `uart_rx_ctrl`

## Requirements
- R1: After reset the enable bit (control register, address 0, bit 0) is 0, the buffer-full bit and all error flags are 0, and frame strobes are ignored while the enable bit is 0.
- R2: Writing 0 to the enable bit while it is 1 empties the receive buffer and the holding stage, clears all three error flags, and raises `tx_flush` for exactly one cycle, in the cycle after the write.
- R3: A frame strobe whose stop bit is 0 sets the framing flag (status register, address 2, bit 3) one cycle after the strobe.
- R4: Parity is checked only while the parity-enable bit (mode register, address 1, bit 0) is 1. The check is made when the byte moves into the buffer. The parity flag (status bit 2) is set when the XOR of the eight data bits and the received parity bit differs from the parity-sense bit (mode bit 1: 0 means even, 1 means odd).
- R5: A frame received while the buffer is empty appears in the data register (address 3) two cycles after its strobe, with buffer-full (status bit 0) at 1. A read of address 3 returns the byte and clears buffer-full, unless a waiting frame moves in on that same read.
- R6: A frame strobe that arrives while the buffer is full and a frame is already waiting in the holding stage sets the overrun flag (status bit 1). The buffered byte is kept, and the waiting frame is replaced by the new one.
- R7: Writing 1 to a status flag bit clears that flag, and writing 0 leaves it unchanged.
- R8: Writes to the interrupt-mode bit (control bit 1) take effect only while the enable bit is 0. Writes made while it is 1 are ignored.
- R9: `rx_irq` is 1 while the block is enabled and the buffer is full. When the interrupt-mode bit is 1, it is also 1 while any error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the data register) |
| reg_addr | input | 2 | Register address: 0 control, 1 mode, 2 status, 3 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| frm_valid | input | 1 | One-cycle strobe marking a completed frame |
| frm_data | input | 8 | Received data byte |
| frm_par | input | 1 | Received parity bit |
| frm_stop | input | 1 | Received stop bit |
| tx_flush | output | 1 | One-cycle pulse telling the transmit buffer to discard its contents |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
On every cycle, the assertions check that a disabled block holds nothing, that a disabling write flushes and clears, and that a stop-bit fault always lands in the framing flag. They also check that an overrun never disturbs the buffered byte, that flags persist until they are cleared by a one or by disable, and that the interrupt-mode bit is frozen while the block is enabled. Some behaviour depends on the data values involved, and only the bench's scenarios can show it. This covers which byte survives an overrun and which one the following read delivers, parity outcomes for both senses with checking on and off, the two-cycle delivery latency, and the interrupt line under each mode.

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          frm_valid,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_par,
  input  logic          frm_stop,
  output logic          tx_flush,
  output logic          rx_irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;
  localparam int PADW = DW - 4;

  logic          en, imode, pen, podd;
  logic          full, sh_valid, sh_par;
  logic          ovr, per, fer;
  logic [DW-1:0] buf_q, sh_data;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_mode = reg_wr && reg_addr == A_MODE;
  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire rd_data = reg_rd && reg_addr == A_DATA;
  wire drop    = wr_ctrl && en && !reg_wdata[0];
  wire move    = sh_valid && (!full || rd_data);
  wire par_bad = pen && ((^{sh_data, sh_par}) != podd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; imode <= 1'b0; pen <= 1'b0; podd <= 1'b0;
      full <= 1'b0; sh_valid <= 1'b0; sh_par <= 1'b0;
      ovr <= 1'b0; per <= 1'b0; fer <= 1'b0;
      buf_q <= '0; sh_data <= '0; tx_flush <= 1'b0;
    end else begin
      tx_flush <= drop;
      if (wr_ctrl) begin
        en <= reg_wdata[0];
        if (!en) imode <= reg_wdata[1];
      end
      if (wr_mode) {podd, pen} <= reg_wdata[1:0];
      if (drop || !en) begin
        full <= 1'b0; sh_valid <= 1'b0;
        ovr <= 1'b0; per <= 1'b0; fer <= 1'b0;
        buf_q <= '0;
      end else begin
        if (frm_valid) begin
          sh_data  <= frm_data;
          sh_par   <= frm_par;
          sh_valid <= 1'b1;
        end else if (move) begin
          sh_valid <= 1'b0;
        end
        if (move) begin
          buf_q <= sh_data;
          full  <= 1'b1;
        end else if (rd_data) begin
          full <= 1'b0;
        end
        ovr <= (ovr && !(wr_stat && reg_wdata[1])) || (frm_valid && sh_valid && !move);
        per <= (per && !(wr_stat && reg_wdata[2])) || (move && par_bad);
        fer <= (fer && !(wr_stat && reg_wdata[3])) || (frm_valid && !frm_stop);
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(DW-2){1'b0}}, imode, en};
      A_MODE:  reg_rdata = {{(DW-2){1'b0}}, podd, pen};
      A_STAT:  reg_rdata = {{PADW{1'b0}}, fer, per, ovr, full};
      default: reg_rdata = buf_q;
    endcase
  end

  assign rx_irq = en && (full || (imode && (ovr || per || fer)));

endmodule

module uart_rx_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          imode,
  input logic          full,
  input logic          sh_valid,
  input logic          ovr,
  input logic          per,
  input logic          fer,
  input logic [DW-1:0] buf_q,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          frm_valid,
  input logic          frm_stop,
  input logic          tx_flush
);

  wire c_wr_ctrl = reg_wr && reg_addr == 2'd0;
  wire c_kill    = c_wr_ctrl && !reg_wdata[0];
  wire c_rd_data = reg_rd && reg_addr == 2'd3;

  p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!full && !sh_valid && !ovr && !per && !fer));

  p_flush_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && c_kill) |=> (tx_flush && !full && !sh_valid && !ovr && !per && !fer));

  p_stop_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frm_valid && !frm_stop && !c_kill) |=> fer);

  p_ovr_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && full && sh_valid && frm_valid && !c_rd_data && !reg_wr) |=> (ovr && $stable(buf_q)));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ovr && !(reg_wr && reg_addr == 2'd2 && reg_wdata[1]) && !c_kill) |=> ovr);

  p_mode_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && c_wr_ctrl) |=> $stable(imode));

endmodule

bind uart_rx_ctrl uart_rx_ctrl_chk #(.DW(DW)) chk_i (.*);

// File: tb/uart_rx_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_rx_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       frm_valid = 1'b0, frm_par = 1'b0, frm_stop = 1'b1;
  logic [7:0] frm_data = 8'd0;
  logic       tx_flush, rx_irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_ctrl dut_i (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic frame(logic [7:0] d, logic p, logic s);
    @(negedge clk); frm_valid = 1'b1; frm_data = d; frm_par = p; frm_stop = s;
    @(negedge clk); frm_valid = 1'b0; frm_stop = 1'b1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    peek(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
    peek(2'd2, v); chk("R1 status after reset", v, 8'h00);
    frame(8'h5A, 1'b0, 1'b0);
    @(negedge clk);
    peek(2'd2, v); chk("R1 frame ignored while disabled", v, 8'h00);
    chk("R1 irq idle", {7'd0, rx_irq}, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    wr(2'd0, 8'h01);
    frame(8'hC3, 1'b0, 1'b1);
    peek(2'd2, v); chk("R5 not yet full one cycle after strobe", v, 8'h00);
    @(negedge clk);
    peek(2'd2, v); chk("R5 full after two cycles", v, 8'h01);
    chk("R9 irq on full", {7'd0, rx_irq}, 8'h01);
    rd(2'd3, v); chk("R5 data byte", v, 8'hC3);
    peek(2'd2, v); chk("R5 read clears full", v, 8'h00);
    chk("R9 irq low after read", {7'd0, rx_irq}, 8'h00);
  endtask

  task automatic t_framing;
    logic [7:0] v;
    frame(8'h11, 1'b0, 1'b0);
    peek(2'd2, v); chk("R3 framing flag after strobe", v & 8'h08, 8'h08);
    @(negedge clk);
    rd(2'd3, v);
    wr(2'd2, 8'h00);
    peek(2'd2, v); chk("R7 write zero keeps flag", v, 8'h08);
    wr(2'd2, 8'h08);
    peek(2'd2, v); chk("R7 write one clears flag", v, 8'h00);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    frame(8'h01, 1'b0, 1'b1); @(negedge clk);
    peek(2'd2, v); chk("R4 parity off ignores mismatch", v, 8'h01);
    rd(2'd3, v);
    wr(2'd1, 8'h01);
    frame(8'h01, 1'b1, 1'b1); @(negedge clk);
    peek(2'd2, v); chk("R4 even parity good", v, 8'h01);
    rd(2'd3, v);
    frame(8'h01, 1'b0, 1'b1); @(negedge clk);
    peek(2'd2, v); chk("R4 even parity bad", v, 8'h05);
    rd(2'd3, v); wr(2'd2, 8'h04);
    wr(2'd1, 8'h03);
    frame(8'h01, 1'b0, 1'b1); @(negedge clk);
    peek(2'd2, v); chk("R4 odd parity good", v, 8'h01);
    rd(2'd3, v);
    frame(8'h03, 1'b0, 1'b1); @(negedge clk);
    peek(2'd2, v); chk("R4 odd parity bad", v, 8'h05);
    rd(2'd3, v); wr(2'd2, 8'h04); wr(2'd1, 8'h00);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    frame(8'hA1, 1'b0, 1'b1); @(negedge clk);
    frame(8'hB2, 1'b0, 1'b1);
    peek(2'd2, v); chk("R6 waiting frame is not overrun", v, 8'h01);
    frame(8'hC3, 1'b0, 1'b1);
    peek(2'd2, v); chk("R6 overrun flag", v, 8'h03);
    rd(2'd3, v); chk("R6 buffered byte kept", v, 8'hA1);
    rd(2'd3, v); chk("R6 holding stage overwritten", v, 8'hC3);
    peek(2'd2, v); chk("R6 buffer empty after both reads", v, 8'h02);
    wr(2'd2, 8'h02);
    peek(2'd2, v); chk("R7 overrun cleared", v, 8'h00);
  endtask

  task automatic t_imode;
    logic [7:0] v;
    wr(2'd0, 8'h03);
    peek(2'd0, v); chk("R8 mode write ignored while enabled", v, 8'h01);
    frame(8'h22, 1'b0, 1'b0); @(negedge clk); rd(2'd3, v);
    chk("R9 irq low on error with mode 0", {7'd0, rx_irq}, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h03);
    peek(2'd0, v); chk("R8 mode write taken while disabled", v, 8'h03);
    frame(8'h22, 1'b0, 1'b0); @(negedge clk); rd(2'd3, v);
    chk("R9 irq on error with mode 1", {7'd0, rx_irq}, 8'h01);
  endtask

  task automatic t_disable;
    logic [7:0] v;
    frame(8'h44, 1'b0, 1'b1); @(negedge clk);
    frame(8'h55, 1'b0, 1'b1);
    frame(8'h66, 1'b0, 1'b1);
    peek(2'd2, v); chk("R2 pre-disable status", v, 8'h0B);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h02;
    @(negedge clk); reg_wr = 1'b0;
    chk("R2 flush pulse", {7'd0, tx_flush}, 8'h01);
    peek(2'd2, v); chk("R2 status cleared", v, 8'h00);
    peek(2'd3, v); chk("R2 buffer emptied", v, 8'h00);
    @(negedge clk);
    chk("R2 flush is one cycle", {7'd0, tx_flush}, 8'h00);
    wr(2'd0, 8'h01);
    frame(8'h77, 1'b0, 1'b1); @(negedge clk);
    rd(2'd3, v); chk("R2 no stale frame after re-enable", v, 8'h77);
    peek(2'd2, v); chk("R2 nothing left waiting", v, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_framing;
    t_parity;
    t_overrun;
    t_imode;
    t_disable;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule